// File: doc/BRIEF.md
# Hotplug Slot Status Register Controller

This block keeps per-bus records of device insertions and removal requests for a set of expansion buses, each carrying 32 slots. System firmware reaches it through a small 32-bit register window. A bus-select register decides which bus the other registers refer to. Firmware reads a bitmap of freshly inserted slots, a bitmap of slots waiting for removal, and a mask of slots that may be removed at run time. It retires one removal request per write by writing a slot bitmap to the eject register. The controller then hands the platform a single-cycle eject command naming the bus and slot.

Plug and unplug notifications arrive on dedicated event inputs. Each accepted notification raises a one-cycle event pulse toward the platform's interrupt logic. A separate per-bus input marks slots whose devices must never be removed.

A platform reset request, and the power-on reset as well, starts a cleanup walk. Every removal still pending is ejected, one slot per cycle, from the lowest bus to the highest. After the walk, the removable-slot masks are rebuilt from the non-removable inputs. A legacy mode keeps the insert bitmap intact when it is read.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, the bus-select register reads 0, the insert bitmaps read 0, and neither the event pulse nor the eject command is active. Once the cleanup walk has finished, each bus's removable mask reads as the inverse of that bus's non-removable input.
- R2: A plug event whose runtime flag is 1 and whose bus index is in range sets that slot's bit in the bus's insert bitmap at offset 0x00, and raises evt_pulse in the following cycle. A plug event with the runtime flag at 0 changes nothing and raises no pulse.
- R3: An in-range unplug event sets that slot's bit in the bus's removal bitmap at offset 0x04, and raises evt_pulse in the following cycle.
- R4: A read of offset 0x00 returns the selected bus's insert bitmap and then clears it. While legacy_mode is 1, the read leaves the bitmap unchanged. Read data appears with reg_rvalid in the cycle after the request.
- R5: A read of offset 0x04 returns the removal bitmap and does not change it.
- R6: Writing a nonzero bitmap to offset 0x08 retires only the lowest-numbered set slot of the selected bus. That slot's bit is cleared in both the insert bitmap and the removal bitmap. One cycle later the eject command carries the bus and slot.
- R7: Ejecting a slot marked non-removable still clears its bits, but no eject command is issued.
- R8: Offset 0x08 reads as 0. Offset 0x10 reads back the last value written to it. Offsets 0x14 and above read as 0.
- R9: While the select value is not below the bus count, reads of offsets 0x00, 0x04 and 0x0C return 0, and eject writes are ignored.
- R10: An access whose byte enables are not all four set (4'hF), or whose address is not word aligned, is ignored. Such a write changes nothing, and such a read returns 0.
- R11: A pulse on sys_reset_req ejects every pending removal, one slot per cycle, lowest bus first and lowest slot first within each bus. Each ejection clears that slot's insert and removal bits. The removable masks are then reloaded as the inverse of the current non-removable inputs.
- R12: If an unplug event and an eject of the same slot land in the same cycle, the slot's removal bit ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | When 1, reading the insert bitmap does not clear it |
| sys_reset_req | input | 1 | Pulse that starts the cleanup walk and mask rebuild |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset inside the window |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data |
| plug_valid | input | 1 | Insertion notification |
| plug_runtime | input | 1 | 1 when the insertion happened at run time |
| plug_bus | input | BUS_W | Bus index of the insertion |
| plug_slot | input | 5 | Slot of the insertion |
| unplug_valid | input | 1 | Removal request |
| unplug_bus | input | BUS_W | Bus index of the removal request |
| unplug_slot | input | 5 | Slot of the removal request |
| fixed_mask | input | NUM_BUS*32 | Per-bus non-removable slot bits, bus b at [b*32 +: 32] |
| evt_pulse | output | 1 | One-cycle notification toward interrupt logic |
| eject_valid | output | 1 | One-cycle eject command |
| eject_bus | output | BUS_W | Bus of the eject command |
| eject_slot | output | 5 | Slot of the eject command |

## Verification
The insert and removal bitmaps are exercised with single-slot events, with multi-bit eject writes, and with runtime and power-up plug events. Multi-bit eject writes show that only the lowest slot is retired. Runtime versus power-up plug events show which insertions are counted. Reads repeated under normal and legacy mode separate clear-on-read from plain reads. Out-of-range selects, partial byte enables and a collision between an unplug and an eject probe the gating paths. A cleanup walk over two buses, with one slot marked non-removable, checks the eject order, the silent clearing of the fixed slot and the reloaded masks.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int SLOT_N = 32;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    DR_IDLE    = 2'd0,
    DR_WALK    = 2'd1,
    DR_REBUILD = 2'd2
  } drain_st_e;

  // word offsets (byte address bits [4:2])
  localparam logic [2:0] OFF_INS  = 3'd0;
  localparam logic [2:0] OFF_REM  = 3'd1;
  localparam logic [2:0] OFF_EJ   = 3'd2;
  localparam logic [2:0] OFF_MASK = 3'd3;
  localparam logic [2:0] OFF_SEL  = 3'd4;

  // index of the lowest set bit, 0 when none is set
  function automatic logic [SLOT_W-1:0] low_slot(input logic [SLOT_N-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = SLOT_N - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_bus_status.sv
module hp_bus_status
  import hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_N-1:0] set_ins,
  input  logic [SLOT_N-1:0] set_rem,
  input  logic [SLOT_N-1:0] clr,
  input  logic              rd_clr_ins,
  input  logic              mask_load,
  input  logic [SLOT_N-1:0] mask_val,
  output logic [SLOT_N-1:0] ins_q,
  output logic [SLOT_N-1:0] rem_q,
  output logic [SLOT_N-1:0] mask_q
);
  logic [SLOT_N-1:0] ins_d, rem_d;
  logic              ins_en, rem_en;

  // clearing by eject has the last word over any set in the same cycle
  always_comb begin
    ins_d  = ((rd_clr_ins ? '0 : ins_q) | set_ins) & ~clr;
    rem_d  = (rem_q | set_rem) & ~clr;
    ins_en = rd_clr_ins | (|set_ins) | (|clr);
    rem_en = (|set_rem) | (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= '0;
      rem_q  <= '0;
      mask_q <= '0;
    end else begin
      if (ins_en)    ins_q  <= ins_d;
      if (rem_en)    rem_q  <= rem_d;
      if (mask_load) mask_q <= mask_val;
    end
  end

  assert_ins_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ins_q & ~$past(ins_q))) |-> $past(|set_ins));

  assert_rem_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != $past(rem_q)) |-> $past(|(set_rem | clr)));

  assert_clr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|clr) |-> ((rem_q & $past(clr)) == '0));

  assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != $past(mask_q)) |-> $past(mask_load));
endmodule

// File: rtl/hp_drain_seq.sv
module hp_drain_seq
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int BUS_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_BUS*SLOT_N-1:0] rem_flat,
  output logic                      busy,
  output logic                      clr_valid,
  output logic [BUS_W-1:0]          clr_bus,
  output logic [SLOT_W-1:0]         clr_slot,
  output logic                      rebuild
);
  localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

  drain_st_e         state_q, state_d;
  logic [BUS_W-1:0]  bus_q, bus_d;
  logic [SLOT_N-1:0] rem_arr [NUM_BUS];
  logic [SLOT_N-1:0] cur_rem;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_unpack
    assign rem_arr[b] = rem_flat[b*SLOT_N +: SLOT_N];
  end

  always_comb begin
    cur_rem   = rem_arr[bus_q];
    state_d   = state_q;
    bus_d     = bus_q;
    clr_valid = 1'b0;
    rebuild   = 1'b0;
    case (state_q)
      DR_WALK: begin
        if (|cur_rem) begin
          clr_valid = 1'b1;
        end else if (bus_q == LAST_BUS) begin
          state_d = DR_REBUILD;
        end else begin
          bus_d = bus_q + 1'b1;
        end
      end
      DR_REBUILD: begin
        rebuild = 1'b1;
        state_d = DR_IDLE;
      end
      default: ;
    endcase
    if (start) begin
      state_d = DR_WALK;
      bus_d   = '0;
    end
  end

  assign clr_bus  = bus_q;
  assign clr_slot = low_slot(cur_rem);
  assign busy     = (state_q != DR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DR_WALK;
      bus_q   <= '0;
    end else begin
      state_q <= state_d;
      bus_q   <= bus_d;
    end
  end

  assert_walk_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DR_WALK && $past(state_q) == DR_WALK && !$past(start))
      |-> (bus_q >= $past(bus_q)));

  assert_rebuild_after_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rebuild |-> $past(state_q == DR_WALK));
endmodule

// File: rtl/hp_reg_if.sv
module hp_reg_if
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int BUS_W   = 2,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_ok,
  output logic [2:0]        off,
  output logic              eject_req,
  output logic              sel_ok,
  output logic [BUS_W-1:0]  sel_idx,
  output logic [DATA_W-1:0] sel_q
);
  logic acc_ok, wr_sel;

  always_comb begin
    acc_ok    = req && (be == 4'hF) && (addr[1:0] == 2'b00);
    off       = addr[ADDR_W-1:2];
    rd_ok     = acc_ok && !wr;
    wr_sel    = acc_ok && wr && (off == OFF_SEL);
    sel_ok    = (sel_q < DATA_W'(NUM_BUS));
    sel_idx   = sel_q[BUS_W-1:0];
    eject_req = acc_ok && wr && (off == OFF_EJ) && sel_ok && (|wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= wdata;
  end

  assert_sel_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_sel) |-> (sel_q == $past(wdata)));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      legacy_mode,
  input  logic                      sys_reset_req,
  input  logic                      reg_req,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [3:0]                reg_be,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic                      reg_rvalid,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic                      plug_valid,
  input  logic                      plug_runtime,
  input  logic [BUS_W-1:0]          plug_bus,
  input  logic [SLOT_W-1:0]         plug_slot,
  input  logic                      unplug_valid,
  input  logic [BUS_W-1:0]          unplug_bus,
  input  logic [SLOT_W-1:0]         unplug_slot,
  input  logic [NUM_BUS*SLOT_N-1:0] fixed_mask,
  output logic                      evt_pulse,
  output logic                      eject_valid,
  output logic [BUS_W-1:0]          eject_bus,
  output logic [SLOT_W-1:0]         eject_slot
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  // register interface
  logic              rd_ok, eject_req, sel_ok;
  logic [2:0]        off;
  logic [BUS_W-1:0]  sel_idx;
  logic [DATA_W-1:0] sel_q;

  hp_reg_if #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_s_n), .req(reg_req), .wr(reg_wr), .addr(reg_addr),
    .be(reg_be), .wdata(reg_wdata), .rd_ok(rd_ok), .off(off), .eject_req(eject_req),
    .sel_ok(sel_ok), .sel_idx(sel_idx), .sel_q(sel_q)
  );

  // cleanup walk
  logic [NUM_BUS*SLOT_N-1:0] rem_flat;
  logic                      busy, dr_valid, rebuild;
  logic [BUS_W-1:0]          dr_bus;
  logic [SLOT_W-1:0]         dr_slot;

  hp_drain_seq #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_drain (
    .clk(clk), .rst_n(rst_s_n), .start(sys_reset_req), .rem_flat(rem_flat),
    .busy(busy), .clr_valid(dr_valid), .clr_bus(dr_bus), .clr_slot(dr_slot),
    .rebuild(rebuild)
  );

  // event acceptance and clear source selection
  logic              plug_acc, unplug_acc;
  logic              clr_valid;
  logic [BUS_W-1:0]  clr_bus;
  logic [SLOT_W-1:0] clr_slot;

  always_comb begin
    plug_acc   = plug_valid && plug_runtime && (32'(plug_bus) < NUM_BUS);
    unplug_acc = unplug_valid && (32'(unplug_bus) < NUM_BUS);
    if (busy) begin
      clr_valid = dr_valid;
      clr_bus   = dr_bus;
      clr_slot  = dr_slot;
    end else begin
      clr_valid = eject_req;
      clr_bus   = sel_idx;
      clr_slot  = low_slot(reg_wdata);
    end
  end

  // per-bus status
  logic [SLOT_N-1:0] ins_arr   [NUM_BUS];
  logic [SLOT_N-1:0] rem_arr   [NUM_BUS];
  logic [SLOT_N-1:0] mask_arr  [NUM_BUS];
  logic [SLOT_N-1:0] fixed_arr [NUM_BUS];

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [SLOT_N-1:0] set_ins_v, set_rem_v, clr_v;
    logic              rd_clr_v;

    always_comb begin
      set_ins_v = (plug_acc && plug_bus == BUS_W'(b)) ? (SLOT_N'(1) << plug_slot) : '0;
      set_rem_v = (unplug_acc && unplug_bus == BUS_W'(b)) ? (SLOT_N'(1) << unplug_slot) : '0;
      clr_v     = (clr_valid && clr_bus == BUS_W'(b)) ? (SLOT_N'(1) << clr_slot) : '0;
      rd_clr_v  = rd_ok && (off == OFF_INS) && sel_ok && (sel_idx == BUS_W'(b)) && !legacy_mode;
    end

    assign fixed_arr[b]               = fixed_mask[b*SLOT_N +: SLOT_N];
    assign rem_flat[b*SLOT_N +: SLOT_N] = rem_arr[b];

    hp_bus_status u_stat (
      .clk(clk), .rst_n(rst_s_n), .set_ins(set_ins_v), .set_rem(set_rem_v),
      .clr(clr_v), .rd_clr_ins(rd_clr_v), .mask_load(rebuild),
      .mask_val(~fixed_arr[b]), .ins_q(ins_arr[b]), .rem_q(rem_arr[b]),
      .mask_q(mask_arr[b])
    );
  end

  // read mux
  logic [DATA_W-1:0] rdata_d;
  logic              rd_any, ej_fire;

  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      case (off)
        OFF_INS:  rdata_d = sel_ok ? ins_arr[sel_idx]  : '0;
        OFF_REM:  rdata_d = sel_ok ? rem_arr[sel_idx]  : '0;
        OFF_MASK: rdata_d = sel_ok ? mask_arr[sel_idx] : '0;
        OFF_SEL:  rdata_d = sel_q;
        default:  rdata_d = '0;
      endcase
    end
    rd_any  = reg_req && !reg_wr;
    ej_fire = clr_valid && !fixed_arr[clr_bus][clr_slot];
  end

  // output registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      reg_rvalid  <= 1'b0;
      reg_rdata   <= '0;
      evt_pulse   <= 1'b0;
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      reg_rvalid  <= rd_any;
      if (rd_any) reg_rdata <= rdata_d;
      evt_pulse   <= plug_acc || unplug_acc;
      eject_valid <= ej_fire;
      if (ej_fire) begin
        eject_bus  <= clr_bus;
        eject_slot <= clr_slot;
      end
    end
  end

  assert_evt_source_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    evt_pulse |-> $past(plug_valid || unplug_valid));

  assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_rvalid && $past(!sel_ok && (reg_addr[4:2] == OFF_REM))) |-> (reg_rdata == '0));
endmodule

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_BUS    = 4;
  localparam int BUS_W      = 2;

  logic clk, rst_n, legacy_mode, sys_reset_req;
  logic reg_req, reg_wr, reg_rvalid;
  logic [4:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic plug_valid, plug_runtime, unplug_valid;
  logic [BUS_W-1:0] plug_bus, unplug_bus, eject_bus;
  logic [4:0] plug_slot, unplug_slot, eject_slot;
  logic [NUM_BUS*32-1:0] fixed_mask;
  logic evt_pulse, eject_valid;

  hp_slot_ctrl #(.NUM_BUS(NUM_BUS)) i_hp_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .sys_reset_req(sys_reset_req),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .plug_valid(plug_valid), .plug_runtime(plug_runtime), .plug_bus(plug_bus),
    .plug_slot(plug_slot), .unplug_valid(unplug_valid), .unplug_bus(unplug_bus),
    .unplug_slot(unplug_slot), .fixed_mask(fixed_mask), .evt_pulse(evt_pulse),
    .eject_valid(eject_valid), .eject_bus(eject_bus), .eject_slot(eject_slot)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] rd_exp_q [$];
  string       rd_tag_q [$];
  logic [6:0]  ej_exp_q [$];
  string       ej_tag_q [$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data and eject commands against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_rvalid) begin
        if (rd_exp_q.size() == 0) chk("unexpected read data", reg_rdata, 32'hx);
        else chk(rd_tag_q.pop_front(), reg_rdata, rd_exp_q.pop_front());
      end
      if (eject_valid) begin
        if (ej_exp_q.size() == 0) chk("R7 unexpected eject", {25'd0, eject_bus, eject_slot}, 32'hx);
        else chk(ej_tag_q.pop_front(), {25'd0, eject_bus, eject_slot}, {25'd0, ej_exp_q.pop_front()});
      end
    end
  end

  // all driver tasks start and end just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag,
                    input logic [3:0] be = 4'hF);
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_be = be;
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic exp_eject(input logic [1:0] b, input logic [4:0] s, input string tag);
    ej_exp_q.push_back({b, s}); ej_tag_q.push_back(tag);
  endtask

  task automatic plug(input logic [1:0] b, input logic [4:0] s, input logic rt,
                      input logic exp_evt, input string tag);
    plug_valid = 1'b1; plug_runtime = rt; plug_bus = b; plug_slot = s;
    @(negedge clk);
    plug_valid = 1'b0;
    chk(tag, {31'd0, evt_pulse}, {31'd0, exp_evt});
  endtask

  task automatic unplug(input logic [1:0] b, input logic [4:0] s, input string tag);
    unplug_valid = 1'b1; unplug_bus = b; unplug_slot = s;
    @(negedge clk);
    unplug_valid = 1'b0;
    chk(tag, {31'd0, evt_pulse}, 32'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; legacy_mode = 1'b0; sys_reset_req = 1'b0;
    reg_req = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_be = 4'hF; reg_wdata = '0;
    plug_valid = 1'b0; plug_runtime = 1'b0; plug_bus = '0; plug_slot = '0;
    unplug_valid = 1'b0; unplug_bus = '0; unplug_slot = '0;
    fixed_mask = {32'hFFFF_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0080};
    idle(4);
    rst_n = 1'b1;
    idle(12);

    // R1 reset state
    chk("R1 evt idle", {31'd0, evt_pulse}, 32'd0);
    chk("R1 eject idle", {31'd0, eject_valid}, 32'd0);
    rd(5'h10, 32'd0, "R1 select");
    rd(5'h00, 32'd0, "R1 insert bus0");
    rd(5'h0C, 32'hFFFF_FF7F, "R1 mask bus0");

    // R2 plug events
    plug(2'd0, 5'd5, 1'b1, 1'b1, "R2 runtime plug evt");
    plug(2'd0, 5'd6, 1'b0, 1'b0, "R2 boot plug no evt");
    rd(5'h00, 32'h0000_0020, "R2 insert bit");
    rd(5'h00, 32'd0, "R4 cleared on read");

    // R3 / R5 unplug
    unplug(2'd1, 5'd9, "R3 unplug evt");
    wr(5'h10, 32'd1);
    rd(5'h04, 32'h0000_0200, "R3 remove bit");
    rd(5'h04, 32'h0000_0200, "R5 remove kept");

    // R4 legacy
    legacy_mode = 1'b1;
    plug(2'd1, 5'd2, 1'b1, 1'b1, "R2 plug bus1");
    rd(5'h00, 32'h4, "R4 legacy read");
    rd(5'h00, 32'h4, "R4 legacy no clear");
    legacy_mode = 1'b0;
    rd(5'h00, 32'h4, "R4 normal read");
    rd(5'h00, 32'h0, "R4 normal cleared");

    // R6 lowest slot eject
    unplug(2'd1, 5'd12, "R3 unplug slot12");
    plug(2'd1, 5'd9, 1'b1, 1'b1, "R2 plug slot9");
    exp_eject(2'd1, 5'd9, "R6 eject lowest");
    wr(5'h08, 32'h0000_1200);
    rd(5'h04, 32'h0000_1000, "R6 remove after eject");
    rd(5'h00, 32'h0, "R6 insert after eject");

    // R7 fixed slot
    unplug(2'd1, 5'd0, "R3 unplug slot0");
    wr(5'h08, 32'h1);
    rd(5'h04, 32'h0000_1000, "R7 fixed slot cleared");

    // R8 misc offsets
    rd(5'h08, 32'h0, "R8 eject reads zero");
    rd(5'h10, 32'h1, "R8 select readback");
    rd(5'h14, 32'h0, "R8 beyond window");

    // R10 partial access
    wr(5'h10, 32'd2, 4'h3);
    rd(5'h10, 32'h1, "R10 partial write ignored");
    rd(5'h04, 32'h0, "R10 partial read zero", 4'h1);
    rd(5'h05, 32'h0, "R10 unaligned read zero");
    rd(5'h04, 32'h0000_1000, "R10 state kept");

    // R9 out of range select
    wr(5'h10, 32'd7);
    rd(5'h04, 32'h0, "R9 remove oob");
    rd(5'h0C, 32'h0, "R9 mask oob");
    wr(5'h08, 32'h0000_1000);
    rd(5'h10, 32'd7, "R9 select oob readback");
    wr(5'h10, 32'd1);
    rd(5'h04, 32'h0000_1000, "R9 eject ignored");

    // R12 collision
    exp_eject(2'd1, 5'd12, "R12 eject slot12");
    unplug_valid = 1'b1; unplug_bus = 2'd1; unplug_slot = 5'd12;
    wr(5'h08, 32'h0000_1000);
    unplug_valid = 1'b0;
    rd(5'h04, 32'h0, "R12 clear wins");

    // R11 cleanup walk
    wr(5'h10, 32'd2);
    rd(5'h0C, 32'hFFFF_FFFF, "R1 mask bus2");
    fixed_mask[2*32 +: 32] = 32'h0000_0002;
    unplug(2'd0, 5'd7, "R3 unplug b0s7");
    unplug(2'd0, 5'd3, "R3 unplug b0s3");
    unplug(2'd2, 5'd0, "R3 unplug b2s0");
    plug(2'd0, 5'd3, 1'b1, 1'b1, "R2 plug b0s3");
    exp_eject(2'd0, 5'd3, "R11 drain b0s3");
    exp_eject(2'd2, 5'd0, "R11 drain b2s0");
    sys_reset_req = 1'b1;
    @(negedge clk);
    sys_reset_req = 1'b0;
    idle(12);
    rd(5'h04, 32'h0, "R11 bus2 drained");
    rd(5'h0C, 32'hFFFF_FFFD, "R11 bus2 mask rebuilt");
    wr(5'h10, 32'd0);
    rd(5'h04, 32'h0, "R11 bus0 drained");
    rd(5'h00, 32'h0, "R11 bus0 insert cleared");
    rd(5'h0C, 32'hFFFF_FF7F, "R11 bus0 mask");
    wr(5'h10, 32'd3);
    rd(5'h0C, 32'h0000_FFFF, "R11 bus3 mask");

    idle(4);
    chk("R4 reads all returned", rd_exp_q.size(), 0);
    chk("R11 ejects all seen", ej_exp_q.size(), 0);
    summary();
  end
endmodule